// File: doc/BRIEF.md
# Serial Audio Output Serializer

This block turns parallel stereo sample words into a bit stream on a four-wire serial audio port. The port's bit clock, left/right clock and word clock come from outside the block. The block only frames and shifts data against those clocks; it does not generate them. Each channel word is 24 bits wide and is sent MSB first. A receiver may keep as many of the leading bits as it needs and ignore the rest. A two-bit format input selects one of four framings. A separate input selects whether data is launched on the rising or the falling bit-clock edge.

The three port clocks are sampled in the block's own system clock domain. Every active bit-clock edge becomes one internal launch tick. A new stereo pair is offered through a valid/ready load handshake and waits in a pending buffer. At the start of the next left-channel slot (the frame boundary) it moves into the shadow registers that feed the shifter. A word loaded mid-frame therefore never disturbs the frame being sent. When no new pair has arrived, the previous pair is sent again. A mute input forces every launched bit to zero while it is high.

Top module: `audio_serial_out`

## Requirements
- R1: After reset, `sdata` is 0 and `load_ready` is 1. The shadow words are zero, so only zero bits are sent until a loaded pair takes effect.
- R2: Format 00 (left-justified). A slot starts at the first launch edge at which `lrclk` differs from its value at the previous launch edge. `lrclk` high marks the left channel. Word bit 23 is launched on that edge, then bits 22 down to 0 on the following 23 edges. After that, 0 is sent until the next slot.
- R3: Format 01 (I2S-style). As R2, but bit 23 is launched one edge after the slot start, so the slot-start edge itself carries 0.
- R4: Format 10 (right-justified). The first 16 edges of a slot carry 0. Edges 16 to 31 carry word bits 23 down to 8, so the last bit fills the end of a 32-bit half-frame.
- R5: Format 11 (word-clock aligned). A slot starts at a launch edge where `wclk` is high after being low at the previous launch edge. The channel is taken from `lrclk` at that edge. The 24 bits follow as in R2.
- R6: `edge_sel` = 0 launches data on rising `bclk` edges; `edge_sel` = 1 launches on falling edges.
- R7: Every bit launched while `mute` is high is 0. Muting does not disturb the slot timing or the stored words.
- R8: `load_ready` is high exactly when the pending buffer is empty. A pair is taken when `load_valid` and `load_ready` are both high at a clock edge. `load_ready` then stays low until the next frame boundary.
- R9: A pending pair replaces the shadow pair at the next left-slot start. A pair loaded mid-frame leaves the rest of the current frame unchanged. `load_ready` rises after the swap, and without a new load the same pair repeats every frame.
- R10: `sdata` changes only in response to an active bit-clock edge. It holds its previous bit for at least one system clock after the edge and shows the new bit two system clocks after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than `bclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock from the port |
| lrclk | input | 1 | Left/right clock, high for the left channel |
| wclk | input | 1 | Word clock, used by format 11 |
| edge_sel | input | 1 | 0: launch on rising `bclk`, 1: launch on falling `bclk` |
| fmt | input | 2 | Framing: 00 left, 01 I2S, 10 right, 11 word clock |
| mute | input | 1 | Forces launched bits to zero |
| load_valid | input | 1 | A new stereo pair is offered |
| load_ready | output | 1 | Pending buffer empty, a pair can be taken |
| left_word | input | 24 | Left-channel sample offered with `load_valid` |
| right_word | input | 24 | Right-channel sample offered with `load_valid` |
| sdata | output | 1 | Serial data line |

## Verification
Each of the four framings is driven with distinct left and right words whose bit patterns are asymmetric. An offset of even one bit, a swapped channel or a truncated word therefore changes the expected bit stream. The I2S and word-clock framings run on the falling launch edge, the other two on the rising edge, so an inverted edge choice shows up as stale or shifted bits. A pair loaded between the left and right slots must leave that frame's right slot on the old data and appear in the next frame. A frame with no new load must repeat the pair. A muted frame between two live frames must be all zeros and must not upset the frame that follows.

// File: rtl/aso_pkg.sv
// Shared types for the serial audio output serializer.
package aso_pkg;

    // Framing selection carried on the two-bit format input.
    typedef enum logic [1:0] {
        FMT_LEFT  = 2'b00,
        FMT_I2S   = 2'b01,
        FMT_RIGHT = 2'b10,
        FMT_WORD  = 2'b11
    } fmt_e;

endpackage

// File: rtl/aso_clk_sampler.sv
// Samples the external port clocks in the system clock domain and
// produces a one-cycle launch tick for each active bit-clock edge.
// Assumes: bclk, lrclk and wclk are slow against clk (each bclk phase
// lasts at least two clk cycles) and lrclk/wclk are stable around the
// active bclk edge; no metastability hardening is done here.
module aso_clk_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic lrclk,
    input  logic wclk,
    input  logic edge_sel,
    output logic tick,
    output logic lr_s,
    output logic wc_s
);

    logic bclk_q;
    logic bclk_d;

    // Register the port clocks; keep one older copy of bclk for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            bclk_d <= 1'b0;
            lr_s   <= 1'b0;
            wc_s   <= 1'b0;
        end else begin
            bclk_q <= bclk;
            bclk_d <= bclk_q;
            lr_s   <= lrclk;
            wc_s   <= wclk;
        end
    end

    // Pick the edge polarity that launches data.
    always_comb begin
        if (edge_sel) begin
            tick = bclk_d & ~bclk_q;
        end else begin
            tick = bclk_q & ~bclk_d;
        end
    end

endmodule

// File: rtl/aso_slot_timer.sv
// Tracks channel slots: finds the slot start for the selected framing,
// counts launch ticks within the slot and marks the frame boundary
// (start of a left slot). Outputs the count and channel that apply to
// the current tick.
// Assumes: one tick per active bit-clock edge from the sampler.
module aso_slot_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             lr_s,
    input  logic             wc_s,
    input  aso_pkg::fmt_e    fmt,
    output logic [CNT_W-1:0] cnt_next,
    output logic             chan_next,
    output logic             slot_start,
    output logic             frame_start
);
    import aso_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic             chan;
    logic             lr_last;
    logic             wc_last;

    // Decide whether this tick opens a new slot.
    always_comb begin
        if (fmt == FMT_WORD) begin
            slot_start = tick & wc_s & ~wc_last;
        end else begin
            slot_start = tick & (lr_s ^ lr_last);
        end
        frame_start = slot_start & lr_s;
    end

    // Count and channel that the current tick uses.
    always_comb begin
        if (slot_start) begin
            cnt_next  = '0;
            chan_next = lr_s;
        end else begin
            cnt_next  = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
            chan_next = chan;
        end
    end

    // Hold slot state and clock levels seen at the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= CNT_MAX;
            chan    <= 1'b0;
            lr_last <= 1'b0;
            wc_last <= 1'b0;
        end else if (tick) begin
            cnt     <= cnt_next;
            chan    <= chan_next;
            lr_last <= lr_s;
            wc_last <= wc_s;
        end
    end

endmodule

// File: rtl/aso_word_buffer.sv
// Two-level word storage: a pending pair filled by the load handshake
// and a shadow pair that feeds the shifter, swapped at frame boundaries.
// The current words are forwarded in the swap cycle so the first bit
// of the new frame already uses the new pair.
// Assumes: frame_start is a single-cycle pulse.
module aso_word_buffer #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    input  logic              frame_start,
    output logic              load_ready,
    output logic [WORD_W-1:0] left_cur,
    output logic [WORD_W-1:0] right_cur
);

    localparam int CHANS = 2;

    logic                         pend_v;
    logic                         take;
    logic                         swap;
    logic [CHANS-1:0][WORD_W-1:0] in_w;
    logic [CHANS-1:0][WORD_W-1:0] cur_w;

    assign load_ready = ~pend_v;
    assign take       = load_valid & ~pend_v;
    assign swap       = frame_start & pend_v;
    assign in_w[0]    = left_in;
    assign in_w[1]    = right_in;
    assign left_cur   = cur_w[0];
    assign right_cur  = cur_w[1];

    // Pending flag: set on a taken load, cleared by the frame swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
        end else if (take) begin
            pend_v <= 1'b1;
        end else if (swap) begin
            pend_v <= 1'b0;
        end
    end

    for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
        logic [WORD_W-1:0] pend_w;
        logic [WORD_W-1:0] shad_w;

        // Capture the offered word for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_w <= '0;
            end else if (take) begin
                pend_w <= in_w[ch];
            end
        end

        // Move the pending word into the shadow at the frame boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shad_w <= '0;
            end else if (swap) begin
                shad_w <= pend_w;
            end
        end

        // Forward the pending word during the swap cycle.
        assign cur_w[ch] = swap ? pend_w : shad_w;
    end

endmodule

// File: rtl/aso_bit_picker.sv
// Chooses the bit launched on each tick from the slot count, the framing
// and the active channel word, applies mute and registers the data line.
// Assumes: RJ_BITS <= WORD_W and the counter is wide enough to reach
// RJ_DELAY + RJ_BITS without wrapping.
module aso_bit_picker #(
    parameter int WORD_W   = 24,
    parameter int RJ_BITS  = 16,
    parameter int RJ_DELAY = 16,
    parameter int CNT_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  aso_pkg::fmt_e     fmt,
    input  logic              mute,
    input  logic [CNT_W-1:0]  cnt_next,
    input  logic              chan_next,
    input  logic [WORD_W-1:0] left_cur,
    input  logic [WORD_W-1:0] right_cur,
    output logic              sdata
);
    import aso_pkg::*;

    localparam int REL_W = CNT_W + 1;

    logic [CNT_W-1:0]  off;
    logic [CNT_W-1:0]  nbits;
    logic [REL_W-1:0]  rel;
    logic [WORD_W-1:0] word;
    logic              bit_now;

    // Start offset and bit count of the selected framing.
    always_comb begin
        case (fmt)
            FMT_I2S: begin
                off   = CNT_W'(1);
                nbits = CNT_W'(WORD_W);
            end
            FMT_RIGHT: begin
                off   = CNT_W'(RJ_DELAY);
                nbits = CNT_W'(RJ_BITS);
            end
            default: begin
                off   = '0;
                nbits = CNT_W'(WORD_W);
            end
        endcase
    end

    // Select the word bit for this tick, MSB first, zero outside the word.
    always_comb begin
        rel     = {1'b0, cnt_next} - {1'b0, off};
        word    = chan_next ? left_cur : right_cur;
        bit_now = 1'b0;
        if ((cnt_next >= off) && (rel < {1'b0, nbits})) begin
            for (int i = 0; i < WORD_W; i++) begin
                if (rel == REL_W'(WORD_W - 1 - i)) begin
                    bit_now = word[i];
                end
            end
        end
        if (mute) begin
            bit_now = 1'b0;
        end
    end

    // Launch the chosen bit on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata <= 1'b0;
        end else if (tick) begin
            sdata <= bit_now;
        end
    end

endmodule

// File: rtl/audio_serial_out.sv
// Serial audio output serializer: frames 24-bit stereo words onto a
// four-wire port whose clocks are supplied from outside. Supports
// left-justified, I2S-style, right-justified and word-clock framings,
// selectable launch edge and a mute that zeroes the data line.
// Assumes: clk runs at least four times faster than bclk; format and
// edge selection change only while in reset.
module audio_serial_out #(
    parameter int WORD_W   = 24,
    parameter int RJ_BITS  = 16,
    parameter int RJ_DELAY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              lrclk,
    input  logic              wclk,
    input  logic              edge_sel,
    input  logic [1:0]        fmt,
    input  logic              mute,
    input  logic              load_valid,
    output logic              load_ready,
    input  logic [WORD_W-1:0] left_word,
    input  logic [WORD_W-1:0] right_word,
    output logic              sdata
);
    import aso_pkg::*;

    localparam int SPAN_RJ = RJ_DELAY + RJ_BITS;
    localparam int SPAN    = ((SPAN_RJ > WORD_W + 1) ? SPAN_RJ : WORD_W + 1) + 1;
    localparam int CNT_W   = $clog2(SPAN + 1);

    fmt_e              fmt_sel;
    logic              tick;
    logic              lr_s;
    logic              wc_s;
    logic [CNT_W-1:0]  cnt_next;
    logic              chan_next;
    logic              slot_start;
    logic              frame_start;
    logic [WORD_W-1:0] left_cur;
    logic [WORD_W-1:0] right_cur;

    assign fmt_sel = fmt_e'(fmt);

    aso_clk_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .lrclk    (lrclk),
        .wclk     (wclk),
        .edge_sel (edge_sel),
        .tick     (tick),
        .lr_s     (lr_s),
        .wc_s     (wc_s)
    );

    aso_slot_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .lr_s        (lr_s),
        .wc_s        (wc_s),
        .fmt         (fmt_sel),
        .cnt_next    (cnt_next),
        .chan_next   (chan_next),
        .slot_start  (slot_start),
        .frame_start (frame_start)
    );

    aso_word_buffer #(
        .WORD_W (WORD_W)
    ) u_buffer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_valid  (load_valid),
        .left_in     (left_word),
        .right_in    (right_word),
        .frame_start (frame_start),
        .load_ready  (load_ready),
        .left_cur    (left_cur),
        .right_cur   (right_cur)
    );

    aso_bit_picker #(
        .WORD_W   (WORD_W),
        .RJ_BITS  (RJ_BITS),
        .RJ_DELAY (RJ_DELAY),
        .CNT_W    (CNT_W)
    ) u_picker (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .fmt       (fmt_sel),
        .mute      (mute),
        .cnt_next  (cnt_next),
        .chan_next (chan_next),
        .left_cur  (left_cur),
        .right_cur (right_cur),
        .sdata     (sdata)
    );

endmodule

// File: rtl/aso_out_checker.sv
// Property checks for the serializer, attached to the top by bind.
// Observes ports plus the launch tick and slot markers.
module aso_out_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       slot_start,
    input logic       frame_start,
    input logic [1:0] fmt,
    input logic       mute,
    input logic       load_valid,
    input logic       load_ready,
    input logic       sdata
);

    // R7
    mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mute) |=> !sdata);

    // R10
    sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sdata));

    // R8
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_ready) |=> !load_ready);

    // R9
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !load_ready) |=> load_ready);

    // R4
    rj_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && fmt == 2'b10) |=> !sdata);

    // R3
    i2s_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && fmt == 2'b01) |=> !sdata);

endmodule

bind audio_serial_out aso_out_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .slot_start  (slot_start),
    .frame_start (frame_start),
    .fmt         (fmt),
    .mute        (mute),
    .load_valid  (load_valid),
    .load_ready  (load_ready),
    .sdata       (sdata)
);

// File: tb/tb_audio_serial_out.sv
// Scoreboard bench: the tick driver pushes the expected bit per launch
// edge, the monitor pops and compares after the output settles.
module tb_audio_serial_out;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        lrclk = 1'b0;
    logic        wclk = 1'b0;
    logic        edge_sel = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        mute = 1'b0;
    logic        load_valid = 1'b0;
    logic        load_ready;
    logic [23:0] left_word = '0;
    logic [23:0] right_word = '0;
    logic        sdata;

    int checks = 0;
    int fails  = 0;

    logic  exp_q[$];
    string tag_q[$];
    event  sample_ev;
    string cur_tag = "R2";
    logic  prev_exp = 1'b0;

    // Bench model of stored words (from R1, R8, R9).
    logic [23:0] m_sh_l, m_sh_r, m_pd_l, m_pd_r;
    logic        m_pd_v;

    always #4 clk = ~clk;

    audio_serial_out dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk),
        .lrclk      (lrclk),
        .wclk       (wclk),
        .edge_sel   (edge_sel),
        .fmt        (fmt),
        .mute       (mute),
        .load_valid (load_valid),
        .load_ready (load_ready),
        .left_word  (left_word),
        .right_word (right_word),
        .sdata      (sdata)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [1:0] f, input int t, input logic [23:0] w);
        int off;
        int n;
        off = (f == 2'b01) ? 1 : ((f == 2'b10) ? 16 : 0);
        n   = (f == 2'b10) ? 16 : 24;
        if (t >= off && t - off < n) return w[23 - (t - off)];
        return 1'b0;
    endfunction

    // Monitor: pop expected bit and compare with the data line.
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() > 0) begin
                logic  e;
                string g;
                e = exp_q.pop_front();
                g = tag_q.pop_front();
                chk(g, {31'd0, sdata}, {31'd0, e});
            end
        end
    end

    // One launch edge: set lr/wc on the inactive phase, then the active edge.
    task automatic drive_tick(input logic lr, input logic wc, input logic exp);
        @(negedge clk);
        bclk  = edge_sel ? 1'b1 : 1'b0;
        lrclk = lr;
        wclk  = wc;
        repeat (3) @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(cur_tag);
        bclk = edge_sel ? 1'b0 : 1'b1;
        @(negedge clk);
        // R10: one clock after the edge the old bit is still present
        chk("R10", {31'd0, sdata}, {31'd0, prev_exp});
        repeat (2) @(negedge clk);
        prev_exp = exp;
        -> sample_ev;
    endtask

    task automatic run_slot(input logic lr);
        for (int t = 0; t < 32; t++) begin
            logic [23:0] w;
            logic        e;
            if (t == 0 && lr && m_pd_v) begin
                m_sh_l = m_pd_l;
                m_sh_r = m_pd_r;
                m_pd_v = 1'b0;
            end
            w = lr ? m_sh_l : m_sh_r;
            e = mute ? 1'b0 : exp_bit(fmt, t, w);
            drive_tick(lr, (t == 0), e);
        end
    endtask

    task automatic run_frame();
        run_slot(1'b1);
        run_slot(1'b0);
    endtask

    task automatic load_pair(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        chk("R8 ready before load", {31'd0, load_ready}, 32'd1);
        left_word  = l;
        right_word = r;
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        chk("R8 ready after load", {31'd0, load_ready}, 32'd0);
        m_pd_l = l;
        m_pd_r = r;
        m_pd_v = 1'b1;
    endtask

    task automatic do_reset(input logic [1:0] f, input logic es, input string tag);
        @(negedge clk);
        rst_n    = 1'b0;
        fmt      = f;
        edge_sel = es;
        bclk     = es;
        lrclk    = 1'b0;
        wclk     = 1'b0;
        mute     = 1'b0;
        repeat (4) @(negedge clk);
        rst_n    = 1'b1;
        m_sh_l   = '0;
        m_sh_r   = '0;
        m_pd_v   = 1'b0;
        prev_exp = 1'b0;
        @(negedge clk);
        chk("R1 sdata", {31'd0, sdata}, 32'd0);
        chk("R1 ready", {31'd0, load_ready}, 32'd1);
        cur_tag = "R1";
        drive_tick(1'b0, 1'b0, 1'b0);
        drive_tick(1'b0, 1'b0, 1'b0);
        cur_tag = tag;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog got=hung exp=done");
        finish_run();
    end

    initial begin
        // Left-justified, rising edge, plus handshake and shadow behaviour
        do_reset(2'b00, 1'b0, "R2");
        load_pair(24'hA5C30F, 24'h3C81E7);
        run_frame();
        cur_tag = "R9";
        run_slot(1'b1);
        load_pair(24'h5A0FF1, 24'hC3247E);     // mid-frame load
        run_slot(1'b0);                         // R9: still old right word
        chk("R8 ready held mid-frame", {31'd0, load_ready}, 32'd0);
        run_slot(1'b1);
        chk("R9 ready after swap", {31'd0, load_ready}, 32'd1);
        run_slot(1'b0);
        run_frame();                            // R9: pair repeats

        // I2S-style, falling edge (R3, R6)
        do_reset(2'b01, 1'b1, "R3 R6");
        load_pair(24'hF0E1D2, 24'h0D1E2F);
        run_frame();
        run_frame();

        // Right-justified, rising edge (R4)
        do_reset(2'b10, 1'b0, "R4");
        load_pair(24'h9B3D67, 24'h6C52A9);
        run_frame();
        run_frame();

        // Word-clock aligned, falling edge (R5, R6)
        do_reset(2'b11, 1'b1, "R5 R6");
        load_pair(24'h81FF18, 24'h7E00E7);
        run_frame();
        run_frame();

        // Mute between live frames (R7)
        do_reset(2'b00, 1'b0, "R7");
        load_pair(24'hFFFFFF, 24'hE5B7D3);
        run_frame();
        mute = 1'b1;
        run_frame();
        mute = 1'b0;
        run_frame();

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule